// File: doc/BRIEF.md
# Open-Page Tracker with Hit Classification and LRU Eviction

This block keeps a table of open rows for a synchronous DRAM controller. The table has one entry per page. A page is one logical bank inside one physical bank. For each accepted access, the block looks the page up and returns one of three outcomes:

- the bank was idle and the row has to be activated;
- the wanted row is already open;
- a different row is open, so the bank must be precharged before the new row is activated.

Each outcome carries the number of cycles the access will wait. This count is the sum of the run-time timing settings that apply to the outcome.

The controller may keep fewer rows open than there are pages. When an activation would go over that cap, the block names the least recently used open page as the one to close. It drops that page from its table in the same step. The controller reports single-page closes and all-bank precharge or refresh events on plain pins. The block only keeps the table. It drives no DRAM command pins.

Requests come in on a valid/ready channel and results leave on a second valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on `rsp_*` in the next cycle. If the result is not taken, `req_ready` stays low, which back-pressures the requester. A close or flush pin held high also holds `req_ready` low for that cycle, so notifications never race an access.

Top module: `page_tracker`

## Requirements
- R1: An access to a page with no open row returns kind 0. Its latency is `cfg_trcd + cfg_cl` for a read. The page's bit in `open_mask` is set after acceptance.
- R2: An access to the row already open in that page returns kind 1. Its latency is `cfg_cl` for a read, and `open_mask` is unchanged.
- R3: An access to a page holding a different row returns kind 2 with read latency `cfg_trp + cfg_trcd + cfg_cl`. The new row replaces the old one, so a repeat of the same access is kind 1. Kind code 3 is never produced.
- R4: For a write (`req_write`=1), `cfg_cl` is left out of the latency for all three kinds.
- R5: The page index is `req_pbank * LBANKS + req_lbank`. Bit i of `open_mask` and the value of `rsp_victim` both use this index.
- R6: The number of set bits in `open_mask` never exceeds `OPEN_CAP`. A kind-0 access made while `OPEN_CAP` pages are open sets `rsp_evict`, and that page's bit is cleared. `rsp_evict` is only ever set with kind 0.
- R7: The victim is the open page least recently accessed or opened. Every accepted access refreshes the recency of its page, whatever its kind. If two open pages are equally old, the one with the lowest index is chosen.
- R8: A pulse on `close_en` clears the bit of page `close_page`. If that page is not open, nothing changes.
- R9: A pulse on `flush_en` clears every bit of `open_mask` and all recency history.
- R10: After reset, `rsp_valid`=0 and `open_mask`=0. `req_ready` is low while a result is held with `rsp_ready` low, and while `close_en` or `flush_en` is high. A held result stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 4 | Activate-to-column delay, in cycles |
| cfg_trp | input | 4 | Precharge delay, in cycles |
| cfg_cl | input | 4 | Column-to-data read delay, in cycles |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be accepted |
| req_lbank | input | 2 | Logical bank of the access |
| req_pbank | input | 1 | Physical bank of the access |
| req_row | input | 12 | Row of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_kind | output | 2 | 0 idle bank, 1 row open, 2 other row open |
| rsp_lat | output | 6 | Latency of the access, in cycles |
| rsp_evict | output | 1 | A page was closed to make room |
| rsp_victim | output | 3 | Index of the page closed to make room |
| close_en | input | 1 | Close one page |
| close_page | input | 3 | Index of the page to close |
| flush_en | input | 1 | Close all pages |
| open_mask | output | 8 | One bit per page, set while a row is open |

## Verification
The properties assume three things about the inputs:
- request fields hold steady while a request waits;
- timing settings change only while nothing is in flight;
- `close_page` names an existing page.

The bench changes request fields only at falling edges, after an accepted edge or while the request is deasserted. It sets the timing inputs once, before reset is released. Its close indices stay below the page count. It pulses close and flush for exactly one cycle with no request pending, so the back-pressure those pins cause is seen only where the bench checks for it.

// File: rtl/pgtrk_pkg.sv
package pgtrk_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_FAST = 2'd1,
    KIND_MISS = 2'd2
  } kind_e;
endpackage

// File: rtl/pgtrk_latency.sv
module pgtrk_latency #(
  parameter int TW = 4,
  localparam int LW = TW + 2
) (
  input  logic [1:0]    kind,
  input  logic          is_write,
  input  logic [TW-1:0] trcd,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] cl,
  output logic [LW-1:0] lat
);
  import pgtrk_pkg::*;

  logic [LW-1:0] part_pre, part_act, part_col;

  always_comb begin
    part_pre = (kind == KIND_MISS) ? LW'(trp)  : '0;
    part_act = (kind != KIND_FAST) ? LW'(trcd) : '0;
    part_col = is_write            ? '0        : LW'(cl);
    lat      = part_pre + part_act + part_col;
  end
endmodule

// File: rtl/pgtrk_victim.sv
module pgtrk_victim #(
  parameter int NPAGE  = 8,
  parameter int RANK_W = 3,
  localparam int PAGE_W = $clog2(NPAGE),
  localparam int CNT_W  = $clog2(NPAGE + 1)
) (
  input  logic [NPAGE-1:0]             open_q,
  input  logic [NPAGE-1:0][RANK_W-1:0] rank_q,
  output logic [PAGE_W-1:0]            victim,
  output logic [CNT_W-1:0]             count
);
  logic [RANK_W-1:0] best;
  logic              found;

  // Oldest open page wins; strict compare keeps the lowest index on a tie.
  always_comb begin
    victim = '0;
    best   = '0;
    found  = 1'b0;
    count  = '0;
    for (int i = 0; i < NPAGE; i++) begin
      if (open_q[i]) begin
        count = count + 1'b1;
        if (!found || rank_q[i] > best) begin
          found  = 1'b1;
          best   = rank_q[i];
          victim = PAGE_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/pgtrk_table.sv
module pgtrk_table #(
  parameter int NPAGE  = 8,
  parameter int ROW_W  = 12,
  parameter int RANK_W = 3,
  localparam int PAGE_W = $clog2(NPAGE)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         close_en,
  input  logic [PAGE_W-1:0]            close_idx,
  input  logic                         upd_en,
  input  logic [1:0]                   upd_kind,
  input  logic [PAGE_W-1:0]            upd_idx,
  input  logic [ROW_W-1:0]             upd_row,
  input  logic                         evict,
  input  logic [PAGE_W-1:0]            victim_idx,
  output logic [NPAGE-1:0]             open_q,
  output logic [NPAGE-1:0][ROW_W-1:0]  row_q,
  output logic [NPAGE-1:0][RANK_W-1:0] rank_q
);
  import pgtrk_pkg::*;

  logic              cls_live;
  logic [RANK_W-1:0] cls_rank, upd_rank;

  assign cls_live = close_en && open_q[close_idx];
  assign cls_rank = rank_q[close_idx];
  assign upd_rank = rank_q[upd_idx];

  // Rank 0 is most recent; open pages always hold distinct ranks below the cap.
  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    logic is_upd, is_vic, is_cls, older;
    assign is_upd = (upd_idx == PAGE_W'(g));
    assign is_vic = evict && (victim_idx == PAGE_W'(g));
    assign is_cls = (close_idx == PAGE_W'(g));
    assign older  = (upd_kind == KIND_IDLE) || (rank_q[g] < upd_rank);

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        open_q[g] <= 1'b0;
        rank_q[g] <= '0;
        if (!rst_n) row_q[g] <= '0;
      end else if (cls_live) begin
        if (is_cls) begin
          open_q[g] <= 1'b0;
          rank_q[g] <= '0;
        end else if (open_q[g] && rank_q[g] > cls_rank) begin
          rank_q[g] <= rank_q[g] - 1'b1;
        end
      end else if (upd_en) begin
        if (is_upd) begin
          open_q[g] <= 1'b1;
          row_q[g]  <= upd_row;
          rank_q[g] <= '0;
        end else if (is_vic) begin
          open_q[g] <= 1'b0;
          rank_q[g] <= '0;
        end else if (open_q[g] && older) begin
          rank_q[g] <= rank_q[g] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_tracker.sv
module page_tracker #(
  parameter int LBANKS   = 4,
  parameter int PBANKS   = 2,
  parameter int ROW_W    = 12,
  parameter int OPEN_CAP = 3,
  parameter int TW       = 4,
  localparam int NPAGE   = LBANKS * PBANKS,
  localparam int PAGE_W  = $clog2(NPAGE),
  localparam int LB_W    = (LBANKS > 1) ? $clog2(LBANKS) : 1,
  localparam int PB_W    = (PBANKS > 1) ? $clog2(PBANKS) : 1,
  localparam int RANK_W  = $clog2(NPAGE),
  localparam int CNT_W   = $clog2(NPAGE + 1),
  localparam int LW      = TW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_cl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LB_W-1:0]   req_lbank,
  input  logic [PB_W-1:0]   req_pbank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [LW-1:0]     rsp_lat,
  output logic              rsp_evict,
  output logic [PAGE_W-1:0] rsp_victim,
  input  logic              close_en,
  input  logic [PAGE_W-1:0] close_page,
  input  logic              flush_en,
  output logic [NPAGE-1:0]  open_mask
);
  import pgtrk_pkg::*;

  logic [NPAGE-1:0]             open_q;
  logic [NPAGE-1:0][ROW_W-1:0]  row_q;
  logic [NPAGE-1:0][RANK_W-1:0] rank_q;
  logic [PAGE_W-1:0]            page, lru_idx;
  logic [CNT_W-1:0]             n_open;
  logic                         fire, need_evict;
  kind_e                        kind;
  logic [LW-1:0]                lat;

  assign req_ready = (!rsp_valid || rsp_ready) && !close_en && !flush_en;
  assign fire      = req_valid && req_ready;
  assign page      = PAGE_W'(req_pbank) * PAGE_W'(LBANKS) + PAGE_W'(req_lbank);

  always_comb begin
    if (!open_q[page])              kind = KIND_IDLE;
    else if (row_q[page] == req_row) kind = KIND_FAST;
    else                             kind = KIND_MISS;
  end

  assign need_evict = (kind == KIND_IDLE) && (n_open >= CNT_W'(OPEN_CAP));

  pgtrk_victim #(.NPAGE(NPAGE), .RANK_W(RANK_W)) u_victim (
    .open_q (open_q),
    .rank_q (rank_q),
    .victim (lru_idx),
    .count  (n_open)
  );

  pgtrk_latency #(.TW(TW)) u_lat (
    .kind     (kind),
    .is_write (req_write),
    .trcd     (cfg_trcd),
    .trp      (cfg_trp),
    .cl       (cfg_cl),
    .lat      (lat)
  );

  pgtrk_table #(.NPAGE(NPAGE), .ROW_W(ROW_W), .RANK_W(RANK_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_en),
    .close_en   (close_en),
    .close_idx  (close_page),
    .upd_en     (fire),
    .upd_kind   (kind),
    .upd_idx    (page),
    .upd_row    (req_row),
    .evict      (need_evict),
    .victim_idx (lru_idx),
    .open_q     (open_q),
    .row_q      (row_q),
    .rank_q     (rank_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_kind   <= '0;
      rsp_lat    <= '0;
      rsp_evict  <= 1'b0;
      rsp_victim <= '0;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_kind   <= kind;
      rsp_lat    <= lat;
      rsp_evict  <= need_evict;
      rsp_victim <= need_evict ? lru_idx : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assign open_mask = open_q;
endmodule

// File: rtl/page_tracker_chk.sv
module page_tracker_chk #(
  parameter int NPAGE    = 8,
  parameter int OPEN_CAP = 3,
  parameter int PAGE_W   = 3,
  parameter int LW       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_kind,
  input logic [LW-1:0]     rsp_lat,
  input logic              rsp_evict,
  input logic [PAGE_W-1:0] rsp_victim,
  input logic              close_en,
  input logic              flush_en,
  input logic [NPAGE-1:0]  open_mask
);
  p_kind_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind != 2'd3);

  p_open_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(open_mask) <= OPEN_CAP);

  p_evict_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict) |-> rsp_kind == 2'd0);

  p_close_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |=> $countones(open_mask) <= $countones($past(open_mask)));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> open_mask == '0);

  p_notify_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en || flush_en) |-> !req_ready);

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_lat)
      && $stable(rsp_evict) && $stable(rsp_victim));
endmodule

bind page_tracker page_tracker_chk #(
  .NPAGE(NPAGE), .OPEN_CAP(OPEN_CAP), .PAGE_W(PAGE_W), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_lat(rsp_lat),
  .rsp_evict(rsp_evict), .rsp_victim(rsp_victim), .close_en(close_en),
  .flush_en(flush_en), .open_mask(open_mask)
);

// File: tb/page_tracker_tb.sv
module page_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trcd = 4'd3, cfg_trp = 4'd2, cfg_cl = 4'd5;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_lbank = '0;
  logic        req_pbank = 1'b0;
  logic [11:0] req_row = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [1:0]  rsp_kind;
  logic [5:0]  rsp_lat;
  logic        rsp_evict;
  logic [2:0]  rsp_victim;
  logic        close_en = 1'b0;
  logic [2:0]  close_page = '0;
  logic        flush_en = 1'b0;
  logic [7:0]  open_mask;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_tracker u_dut (.*);

  typedef struct packed {
    logic [1:0]  lb;
    logic        pb;
    logic [11:0] row;
    logic        wr;
    logic [1:0]  kind;
    logic [5:0]  lat;
    logic        ev;
    logic [2:0]  vic;
    logic [7:0]  mask;
  } vec_t;

  // trcd=3 trp=2 cl=5; page = pb*4 + lb
  localparam vec_t VEC [12] = '{
    {2'd0, 1'b0, 12'h010, 1'b0, 2'd0, 6'd8,  1'b0, 3'd0, 8'h01}, // R1 idle read
    {2'd0, 1'b0, 12'h010, 1'b0, 2'd1, 6'd5,  1'b0, 3'd0, 8'h01}, // R2 fast read
    {2'd1, 1'b1, 12'h020, 1'b1, 2'd0, 6'd3,  1'b0, 3'd0, 8'h21}, // R4 R5 idle write page5
    {2'd0, 1'b0, 12'h011, 1'b0, 2'd2, 6'd10, 1'b0, 3'd0, 8'h21}, // R3 miss read
    {2'd0, 1'b0, 12'h011, 1'b1, 2'd1, 6'd0,  1'b0, 3'd0, 8'h21}, // R3 R4 fast write
    {2'd2, 1'b0, 12'h030, 1'b0, 2'd0, 6'd8,  1'b0, 3'd0, 8'h25}, // R1 fill to cap
    {2'd3, 1'b1, 12'h040, 1'b0, 2'd0, 6'd8,  1'b1, 3'd5, 8'h85}, // R6 R7 evict page5
    {2'd0, 1'b0, 12'h011, 1'b0, 2'd1, 6'd5,  1'b0, 3'd0, 8'h85}, // R7 touch page0
    {2'd1, 1'b1, 12'h020, 1'b1, 2'd0, 6'd3,  1'b1, 3'd2, 8'hA1}, // R6 R7 evict page2
    {2'd3, 1'b1, 12'h041, 1'b1, 2'd2, 6'd5,  1'b0, 3'd0, 8'hA1}, // R3 R4 miss write
    {2'd0, 1'b1, 12'h050, 1'b0, 2'd0, 6'd8,  1'b1, 3'd0, 8'hB0}, // R7 evict page0
    {2'd1, 1'b1, 12'h020, 1'b0, 2'd1, 6'd5,  1'b0, 3'd0, 8'hB0}  // R2 fast read
  };

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] lb, input logic pb, input logic [11:0] row,
                      input logic wr);
    @(negedge clk);
    req_lbank = lb; req_pbank = pb; req_row = row; req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_close(input logic [2:0] pg);
    @(negedge clk);
    close_en = 1'b1; close_page = pg;
    #1 check("R10 ready low during close", int'(req_ready), 0);
    @(negedge clk);
    close_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset rsp_valid", int'(rsp_valid), 0);
    check("R10 reset open_mask", int'(open_mask), 0);
    check("R10 reset req_ready", int'(req_ready), 1);

    for (int i = 0; i < 12; i++) begin
      send(VEC[i].lb, VEC[i].pb, VEC[i].row, VEC[i].wr);
      check($sformatf("R10 vec%0d rsp_valid", i), int'(rsp_valid), 1);
      check($sformatf("R1 R2 R3 vec%0d kind", i), int'(rsp_kind), int'(VEC[i].kind));
      check($sformatf("R4 vec%0d latency", i), int'(rsp_lat), int'(VEC[i].lat));
      check($sformatf("R6 vec%0d evict", i), int'(rsp_evict), int'(VEC[i].ev));
      if (VEC[i].ev)
        check($sformatf("R7 vec%0d victim", i), int'(rsp_victim), int'(VEC[i].vic));
      check($sformatf("R5 vec%0d open_mask", i), int'(open_mask), int'(VEC[i].mask));
    end

    // R8: close open page 4, then close an idle page 0 (no effect)
    pulse_close(3'd4);
    check("R8 close page4 mask", int'(open_mask), 8'hA0);
    pulse_close(3'd0);
    check("R8 close idle page mask", int'(open_mask), 8'hA0);

    // Recency after close: page5 newest, page7 oldest
    send(2'd1, 1'b0, 12'h007, 1'b0);
    check("R1 reopen below cap kind", int'(rsp_kind), 0);
    check("R6 no evict below cap", int'(rsp_evict), 0);
    check("R1 mask after page1 open", int'(open_mask), 8'hA2);
    send(2'd3, 1'b0, 12'h009, 1'b0);
    check("R6 evict at cap", int'(rsp_evict), 1);
    check("R7 victim oldest page7", int'(rsp_victim), 7);
    check("R6 mask after evict", int'(open_mask), 8'h2A);

    // R10: back-pressure holds result and blocks requests
    @(negedge clk);
    rsp_ready = 1'b0;
    send(2'd1, 1'b0, 12'h007, 1'b0);
    check("R10 held rsp_valid", int'(rsp_valid), 1);
    check("R10 ready low while held", int'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    check("R10 held kind stable", int'(rsp_kind), 1);
    check("R10 held latency stable", int'(rsp_lat), 5);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 released rsp_valid", int'(rsp_valid), 0);

    // R9: flush clears everything
    @(negedge clk);
    flush_en = 1'b1;
    #1 check("R10 ready low during flush", int'(req_ready), 0);
    @(negedge clk);
    flush_en = 1'b0;
    check("R9 flush mask", int'(open_mask), 0);
    send(2'd1, 1'b1, 12'h020, 1'b0);
    check("R9 after flush kind idle", int'(rsp_kind), 0);
    check("R9 after flush no evict", int'(rsp_evict), 0);
    check("R9 after flush latency", int'(rsp_lat), 8);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule